// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register File

This block is a watchdog that software has to keep reloading. A programmable prescaler divides the clock into ticks, and a down-counter decrements once per tick, starting from a timeout value that software programs. When the counter runs out, the block sets a sticky timeout flag. On a first expiry it can only ask for a system-management interrupt (SMI), and then it starts counting again. If a second expiry follows with no reload in between, the block flags the event in a second status register. If neither of two inhibit inputs is high, it also fires a one-cycle reboot pulse and stops.

Software reaches the block through a flat synchronous register port made of an address, a write strobe, write data and registered read data. Besides the timeout and the reload, the register file has a control register with a halt bit and a lock bit that cannot be undone. It also has two message bytes, a watchdog-count byte, a free control word and a software-interrupt byte. Finally it has a data-in byte and a data-out byte; writing either of these has a status side effect.

Top module: `wdt_regs`

## Requirements
- R1: After a synchronous reset the timeout register reads 4, the free control word reads 0x0008, the software-interrupt byte reads 0x03, and every other register reads 0. Read data is registered: it shows the register selected by `reg_addr` one clock after that address is presented.
- R2: The counter runs only while the halt bit (control bit 0, address 5) is 0 and the timeout register (address 10) holds a value greater than 1. A timeout of 0 or 1 never starts it.
- R3: A tick occurs once every PRESCALE clocks. A running counter decrements on each tick and expires on a tick where it holds 1 or less. Each expiry sets status-1 bit 0 (address 3).
- R4: A first expiry pulses `smi_req` for one cycle when `smi_enable` is high, reloads the counter from the timeout register and keeps running.
- R5: A second consecutive expiry sets status-2 bits 0 and 1 (address 4). If `strap_inhibit` and `reboot_inhibit` are both low, it pulses `reboot_req` for one cycle and does not pulse `smi_req`. The counter then stops, and the reload register reads 0.
- R6: A second consecutive expiry with either inhibit input high sets the same status-2 bits but gives no reboot pulse. It pulses `smi_req` when `smi_enable` is high, reloads the counter and keeps running.
- R7: A write to the reload register (address 0) restarts the count of consecutive expiries. If the run condition holds, it loads the counter from the timeout register; if not, it stores the written value, which then reads back.
- R8: The lock bit (control bit 1) can be set by software but never cleared by it. A control write starts and reloads the counter if the run condition holds afterwards, and stops the counter if it does not.
- R9: A data-in write (address 1) stores the low byte, sets status-1 bit 1 and pulses `smi_req`. A data-out write (address 2) stores the low byte and sets status-1 bit 2.
- R10: A write to a status register replaces its contents with the written value, masked to the implemented bits: bits [2:0] for status 1 and bits [1:0] for status 2. All other bits read as 0.
- R11: While the counter runs, reading the reload register returns the number of ticks left. While it is stopped, the read returns the stored reload value.
- R12: Addresses 12 to 15 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| smi_enable | input | 1 | Allows expiry to raise an SMI request |
| strap_inhibit | input | 1 | Strap level that blocks the reboot pulse |
| reboot_inhibit | input | 1 | Level that blocks the reboot pulse |
| smi_req | output | 1 | One-cycle SMI request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The expiry path is tried under several inhibit settings: both inhibits low, which must give a reboot, and the strap high, which must give a second SMI. Reloads written between expiries are checked to show that the consecutive count is reset rather than carried over. Timeouts of 0 and 1 are set against a valid timeout, which shows whether the run condition is gated correctly. The halt and lock writes show that the sticky bit holds while the halt bit still follows the data written. Data-in and data-out writes and all-ones status writes show which status bits each source touches. A behavioural model in the bench predicts read data and both pulses on every clock, so any timing that is off by one tick or one cycle stands out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [3:0] {
    A_RELOAD  = 4'd0,
    A_DIN     = 4'd1,
    A_DOUT    = 4'd2,
    A_STAT1   = 4'd3,
    A_STAT2   = 4'd4,
    A_CTRL1   = 4'd5,
    A_CTRL2   = 4'd6,
    A_MSG1    = 4'd7,
    A_MSG2    = 4'd8,
    A_WDCNT   = 4'd9,
    A_TIMEOUT = 4'd10,
    A_SWIRQ   = 4'd11
  } wdt_addr_e;

  localparam int S1_TIMEOUT = 0;
  localparam int S1_SWSMI   = 1;
  localparam int S1_DOUT    = 2;
  localparam int S2_SECOND  = 0;
  localparam int S2_BOOT    = 1;
  localparam int C1_HALT    = 0;
  localparam int C1_LOCK    = 1;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [TW-1:0] tmr,
  input  logic          start,
  input  logic          stop,
  input  logic          clr_consec,
  input  logic          inhibit,
  output logic [TW-1:0] cnt,
  output logic          running,
  output logic          expire,
  output logic          second,
  output logic          kill
);
  logic consec;

  assign expire = running && tick && (cnt <= TW'(1)) && !start && !stop;
  assign second = expire && consec;
  assign kill   = second && !inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      consec  <= 1'b0;
    end else begin
      if (start) begin
        cnt     <= tmr;
        running <= 1'b1;
      end else if (stop) begin
        running <= 1'b0;
      end else if (expire) begin
        if (kill) begin
          running <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= tmr;
        end
      end else if (running && tick) begin
        cnt <= cnt - 1'b1;
      end
      if (clr_consec) consec <= 1'b0;
      else if (expire) consec <= !consec;
    end
  end

  AST_START_NEEDS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(tmr) > TW'(1))); // R2
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (expire && !kill) |=> (running && cnt == $past(tmr))); // R4
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int PRESCALE = 4,
  parameter int AW       = 4,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          smi_enable,
  input  logic          strap_inhibit,
  input  logic          reboot_inhibit,
  output logic          smi_req,
  output logic          reboot_req
);
  import wdt_pkg::*;

  localparam logic [DW-1:0] S1_MASK   = DW'(16'h0007);
  localparam logic [DW-1:0] S2_MASK   = DW'(16'h0003);
  localparam logic [DW-1:0] C1_MASK   = DW'(16'h0003);
  localparam logic [DW-1:0] C2_RESET  = DW'(16'h0008);
  localparam logic [DW-1:0] TMR_RESET = DW'(16'h0004);

  logic [DW-1:0] rld_q, stat1_q, stat2_q, ctrl1_q, ctrl2_q, tmr_q;
  logic [7:0]    din_q, dout_q, msg1_q, msg2_q, wdcnt_q, swirq_q;
  logic [DW-1:0] cnt, ctrl1_new, stat1_nx, stat2_nx;
  logic          tick, running, expire, second, kill;
  logic          wr_rld, wr_c1, wr_din, wr_dout, run_now, run_new;
  logic          start, stop;

  assign wr_rld    = reg_wr && (reg_addr == AW'(A_RELOAD));
  assign wr_c1     = reg_wr && (reg_addr == AW'(A_CTRL1));
  assign wr_din    = reg_wr && (reg_addr == AW'(A_DIN));
  assign wr_dout   = reg_wr && (reg_addr == AW'(A_DOUT));
  assign ctrl1_new = (reg_wdata & C1_MASK) | (ctrl1_q & (DW'(1) << C1_LOCK));
  assign run_now   = !ctrl1_q[C1_HALT] && (tmr_q > DW'(1));
  assign run_new   = !ctrl1_new[C1_HALT] && (tmr_q > DW'(1));
  assign start     = (wr_rld && run_now) || (wr_c1 && run_new);
  assign stop      = wr_c1 && !run_new;

  wdt_prescale #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst(rst), .tick(tick));

  wdt_core #(.TW(DW)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .tmr(tmr_q),
    .start(start), .stop(stop), .clr_consec(wr_rld),
    .inhibit(strap_inhibit || reboot_inhibit),
    .cnt(cnt), .running(running), .expire(expire),
    .second(second), .kill(kill)
  );

  always_comb begin
    stat1_nx = stat1_q;
    stat2_nx = stat2_q;
    if (reg_wr && reg_addr == AW'(A_STAT1)) stat1_nx = reg_wdata & S1_MASK;
    if (reg_wr && reg_addr == AW'(A_STAT2)) stat2_nx = reg_wdata & S2_MASK;
    if (wr_din)  stat1_nx[S1_SWSMI] = 1'b1;
    if (wr_dout) stat1_nx[S1_DOUT]  = 1'b1;
    if (expire)  stat1_nx[S1_TIMEOUT] = 1'b1;
    if (second) begin
      stat2_nx[S2_SECOND] = 1'b1;
      stat2_nx[S2_BOOT]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0; stat1_q <= '0; stat2_q <= '0; ctrl1_q <= '0;
      ctrl2_q <= C2_RESET; tmr_q <= TMR_RESET;
      din_q <= '0; dout_q <= '0; msg1_q <= '0; msg2_q <= '0;
      wdcnt_q <= '0; swirq_q <= 8'h03;
      smi_req <= 1'b0; reboot_req <= 1'b0;
    end else begin
      stat1_q <= stat1_nx;
      stat2_q <= stat2_nx;
      if (reg_wr) begin
        case (reg_addr)
          AW'(A_RELOAD):  rld_q   <= run_now ? tmr_q : reg_wdata;
          AW'(A_DIN):     din_q   <= reg_wdata[7:0];
          AW'(A_DOUT):    dout_q  <= reg_wdata[7:0];
          AW'(A_CTRL1): begin
            ctrl1_q <= ctrl1_new;
            if (run_new) rld_q <= tmr_q;
          end
          AW'(A_CTRL2):   ctrl2_q <= reg_wdata;
          AW'(A_MSG1):    msg1_q  <= reg_wdata[7:0];
          AW'(A_MSG2):    msg2_q  <= reg_wdata[7:0];
          AW'(A_WDCNT):   wdcnt_q <= reg_wdata[7:0];
          AW'(A_TIMEOUT): tmr_q   <= reg_wdata;
          AW'(A_SWIRQ):   swirq_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (expire) rld_q <= kill ? '0 : tmr_q;
      smi_req    <= wr_din || (expire && !kill && smi_enable);
      reboot_req <= kill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        AW'(A_RELOAD):  reg_rdata <= running ? cnt : rld_q;
        AW'(A_DIN):     reg_rdata <= DW'(din_q);
        AW'(A_DOUT):    reg_rdata <= DW'(dout_q);
        AW'(A_STAT1):   reg_rdata <= stat1_q;
        AW'(A_STAT2):   reg_rdata <= stat2_q;
        AW'(A_CTRL1):   reg_rdata <= ctrl1_q;
        AW'(A_CTRL2):   reg_rdata <= ctrl2_q;
        AW'(A_MSG1):    reg_rdata <= DW'(msg1_q);
        AW'(A_MSG2):    reg_rdata <= DW'(msg2_q);
        AW'(A_WDCNT):   reg_rdata <= DW'(wdcnt_q);
        AW'(A_TIMEOUT): reg_rdata <= tmr_q;
        AW'(A_SWIRQ):   reg_rdata <= DW'(swirq_q);
        default:        reg_rdata <= '0;
      endcase
    end
  end

  AST_REBOOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    reboot_req |-> !running); // R5
  AST_REBOOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reboot_req |=> !reboot_req); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl1_q[C1_LOCK]) |-> ctrl1_q[C1_LOCK]); // R8
  AST_SECOND_FLAGS: assert property (@(posedge clk) disable iff (rst)
    second |=> (stat2_q[S2_SECOND] && stat2_q[S2_BOOT])); // R6
endmodule

// File: tb/wdt_regs_bench.sv
module wdt_regs_bench;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic smi_enable = 1'b0, strap_inhibit = 1'b0, reboot_inhibit = 1'b0;
  logic smi_req, reboot_req;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wdt_regs #(.PRESCALE(PRE)) u_wdt_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_enable(smi_enable),
    .strap_inhibit(strap_inhibit), .reboot_inhibit(reboot_inhibit),
    .smi_req(smi_req), .reboot_req(reboot_req)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_run, m_consec, m_rld, m_din, m_dout, m_s1, m_s2;
  int m_c1, m_c2, m_msg1, m_msg2, m_wdc, m_tmr, m_swirq;
  int e_rd, e_smi, e_reb;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_run = 0; m_consec = 0; m_rld = 0;
      m_din = 0; m_dout = 0; m_s1 = 0; m_s2 = 0; m_c1 = 0; m_c2 = 8;
      m_msg1 = 0; m_msg2 = 0; m_wdc = 0; m_tmr = 4; m_swirq = 3;
      e_rd = 0; e_smi = 0; e_reb = 0;
    end else begin
      int wd, tk, st, sp, clr, ex, oldc, okrun;
      wd = int'(reg_wdata);
      case (int'(reg_addr))
        0: e_rd = m_run ? m_cnt : m_rld;
        1: e_rd = m_din;   2: e_rd = m_dout;
        3: e_rd = m_s1;    4: e_rd = m_s2;
        5: e_rd = m_c1;    6: e_rd = m_c2;
        7: e_rd = m_msg1;  8: e_rd = m_msg2;
        9: e_rd = m_wdc;   10: e_rd = m_tmr;
        11: e_rd = m_swirq;
        default: e_rd = 0;
      endcase
      tk = (m_pre == PRE - 1);
      m_pre = tk ? 0 : m_pre + 1;
      st = 0; sp = 0; clr = 0; e_smi = 0; e_reb = 0;
      if (reg_wr) begin
        case (int'(reg_addr))
          0: begin
            clr = 1;
            okrun = ((m_c1 & 1) == 0) && (m_tmr > 1);
            if (okrun) begin st = 1; m_rld = m_tmr; end else m_rld = wd;
          end
          1: begin m_din = wd & 255; m_s1 = m_s1 | 2; e_smi = 1; end
          2: begin m_dout = wd & 255; m_s1 = m_s1 | 4; end
          3: m_s1 = wd & 7;
          4: m_s2 = wd & 3;
          5: begin
            m_c1 = (wd & 3) | (m_c1 & 2);
            okrun = ((m_c1 & 1) == 0) && (m_tmr > 1);
            if (okrun) begin st = 1; m_rld = m_tmr; end else sp = 1;
          end
          6: m_c2 = wd;
          7: m_msg1 = wd & 255;
          8: m_msg2 = wd & 255;
          9: m_wdc = wd & 255;
          10: m_tmr = wd;
          11: m_swirq = wd & 255;
          default: ;
        endcase
      end
      ex = m_run && tk && (m_cnt <= 1) && !st && !sp;
      oldc = m_consec;
      if (st) begin m_cnt = m_tmr; m_run = 1; end
      else if (sp) m_run = 0;
      else if (ex) begin
        m_s1 = m_s1 | 1;
        if (oldc) begin
          m_s2 = m_s2 | 3;
          if (!strap_inhibit && !reboot_inhibit) begin
            e_reb = 1; m_run = 0; m_cnt = 0; m_rld = 0;
          end else begin
            if (smi_enable) e_smi = 1;
            m_cnt = m_tmr; m_rld = m_tmr;
          end
        end else begin
          if (smi_enable) e_smi = 1;
          m_cnt = m_tmr; m_rld = m_tmr;
        end
      end else if (m_run && tk) m_cnt = m_cnt - 1;
      if (clr) m_consec = 0;
      else if (ex) m_consec = oldc ? 0 : 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " rdata"}, int'(reg_rdata), e_rd);
      chk({cur_req, " smi"}, int'(smi_req), e_smi);
      chk({cur_req, " reboot"}, int'(reboot_req), e_reb);
    end
  end

  int smi_seen = 0, reb_seen = 0;
  always @(negedge clk) begin
    if (!rst && smi_req) smi_seen++;
    if (!rst && reboot_req) reb_seen++;
  end

  task automatic wr(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 4'(a);
    @(negedge clk); #1;
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_smi(input int base, input int lim, output int ok);
    ok = 0;
    for (int i = 0; i < lim && !ok; i++) begin
      @(negedge clk); #1;
      if (smi_seen > base) ok = 1;
    end
  endtask

  task automatic wait_reb(input int lim, output int ok);
    ok = 0;
    for (int i = 0; i < lim && !ok; i++) begin
      @(negedge clk); #1;
      if (reb_seen > 0) ok = 1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, ok, s0, r0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    cur_req = "R1";
    rd(0, v);  chk("R1 reload reset", v, 0);
    rd(6, v);  chk("R1 ctrl2 reset", v, 16'h0008);
    rd(10, v); chk("R1 timeout reset", v, 4);
    rd(11, v); chk("R1 swirq reset", v, 3);
    rd(3, v);  chk("R1 stat1 reset", v, 0);
    cur_req = "R12";
    wr(13, 16'hBEEF);
    rd(13, v); chk("R12 unused addr", v, 0);
    rd(15, v); chk("R12 unused addr", v, 0);

    cur_req = "R2";
    smi_enable = 1'b1;
    s0 = smi_seen;
    wr(10, 1); wr(5, 0); idle(30);
    chk("R2 timeout 1 no expiry", smi_seen - s0, 0);
    wr(10, 0); wr(5, 0); idle(10);
    chk("R2 timeout 0 no expiry", smi_seen - s0, 0);
    cur_req = "R7";
    wr(0, 16'h0055);
    rd(0, v); chk("R7 stored reload when stopped", v, 16'h0055);

    cur_req = "R11";
    wr(10, 5); wr(5, 0);
    rd(0, v); chk("R11 remaining in range", int'(v >= 1 && v <= 5), 1);
    cur_req = "R4";
    wait_smi(s0, 5 * PRE + 4, ok); chk("R4 first expiry smi", ok, 1);
    rd(3, v); chk("R3 stat1 timeout bit", v & 1, 1);
    rd(4, v); chk("R4 stat2 clear after first", v, 0);

    cur_req = "R5";
    r0 = reb_seen;
    wait_reb(5 * PRE + 4, ok); chk("R5 second expiry reboot", ok, 1);
    rd(4, v); chk("R5 stat2 flags", v, 3);
    rd(0, v); chk("R5 reload reads 0 after reboot", v, 0);
    idle(40);
    chk("R5 single reboot", reb_seen - r0, 1);

    cur_req = "R6";
    wr(4, 0); wr(3, 0);
    strap_inhibit = 1'b1;
    wr(5, 0);
    s0 = smi_seen;
    wait_smi(s0, 5 * PRE + 4, ok);
    wait_smi(s0 + 1, 5 * PRE + 4, ok); chk("R6 second expiry smi", ok, 1);
    chk("R6 no reboot with strap", reb_seen - r0, 1);
    rd(4, v); chk("R6 stat2 flags", v, 3);
    strap_inhibit = 1'b0; reboot_inhibit = 1'b1;

    cur_req = "R7";
    wr(4, 0);
    s0 = smi_seen;
    wait_smi(s0, 6 * PRE + 4, ok);
    wr(0, 0);
    wait_smi(s0 + 1, 6 * PRE + 4, ok);
    rd(4, v); chk("R7 reload resets consecutive count", v, 0);
    wait_smi(s0 + 2, 6 * PRE + 4, ok);
    rd(4, v); chk("R7 next expiry is second", v, 3);
    chk("R7 no reboot when inhibited", reb_seen - r0, 1);

    cur_req = "R8";
    wr(5, 2);
    rd(5, v); chk("R8 lock set", v, 2);
    wr(5, 1);
    rd(5, v); chk("R8 lock sticky halt set", v, 3);
    wr(5, 0);
    rd(5, v); chk("R8 lock survives clear", v, 2);
    wr(5, 1);
    rd(0, v); idle(3 * PRE);
    rd(0, ok); chk("R8 halted counter frozen", ok, v);

    cur_req = "R9";
    s0 = smi_seen;
    wr(3, 0);
    wr(1, 16'h01A5);
    rd(1, v); chk("R9 data-in byte", v, 16'h00A5);
    chk("R9 data-in smi", smi_seen - s0, 1);
    rd(3, v); chk("R9 stat1 swsmi", v, 2);
    wr(2, 16'h3C5A);
    rd(2, v); chk("R9 data-out byte", v, 16'h005A);
    rd(3, v); chk("R9 stat1 dout", v, 6);

    cur_req = "R10";
    wr(3, 16'hFFFF); rd(3, v); chk("R10 stat1 mask", v, 7);
    wr(4, 16'hFFFF); rd(4, v); chk("R10 stat2 mask", v, 3);
    wr(3, 0); rd(3, v); chk("R10 stat1 cleared", v, 0);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule